// File: doc/BRIEF.md
# Transmit Clock Presence Monitor

This block watches the clock that times the transmit line drivers and takes the drivers off the line when that clock disappears. It runs entirely on a local oscillator clock that never stops. It opens a fixed window of oscillator cycles and records whether the watched clock produced a rising edge inside it. An empty window raises a loss flag, and the flag tri-states both line driver outputs until a window with an edge arrives.

The watched clock depends on where the jitter attenuator sits. When the attenuator is in the transmit path, the attenuator's smoothing clock is watched. Otherwise the raw transmit clock is watched. The same block also protects the drivers against a short. An analog comparator reports the short as a level. At a bit boundary the block turns the drivers off for a fixed number of bit periods, then tries the next bit. It repeats this for as long as the short remains. A test input can force every output enable low.

Top module: `txmon_top`

## Requirements
- R1: A strobe fires once every STROBE_DIV (10) oscillator cycles, counting from reset. The loss flag `out_loss` changes only in the cycle after a strobe, so every value it takes lasts a whole number of 10-cycle windows.
- R2: If a window holds at least one synchronized rising edge of the watched clock, `out_loss` is 0 after the strobe that closes that window. A watched clock with a period of 10 oscillator cycles or less never raises the flag.
- R3: If a window holds no edge, `out_loss` is 1 after the strobe that closes it. A watched clock with a period of P cycles, where 11 ≤ P ≤ 14, keeps the flag high for exactly 10·(P−10) of every 10·P cycles.
- R4: While `out_loss` is 1, both `drv_oe_p` and `drv_oe_n` are 0.
- R5: If `atten_in_tx` = 1, only `smooth_clk` is watched. If `atten_in_tx` = 0, only `tx_clk` is watched. The clock that is not selected has no effect on the flag.
- R6: Suppose `short_sense` is high at a rising edge of the watched clock while the drivers are enabled. Both driver enables then go to 0 for exactly GUARD_BITS (35) watched-clock periods, and after that they return to 1.
- R7: While `short_sense` stays high, protection repeats. After each retry the drivers stay enabled for one watched-clock period before the next 35-period off time. No port reports the short.
- R8: While `force_float` = 1, `drv_oe_p`, `drv_oe_n` and `flag_oe` are all 0, whatever the state of the loss flag and the short protection.
- R9: Right after reset, `out_loss` = 0, the short protection is idle, and the driver enables and `flag_oe` are 1 (with `force_float` = 0).
- R10: The watched clock and the short level each pass through a two-flop synchronizer. Each rising edge of the watched clock produces exactly one single-cycle edge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Always-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atten_in_tx | input | 1 | 1: jitter attenuator in transmit path, watch the smoothing clock |
| tx_clk | input | 1 | Raw transmit clock (asynchronous) |
| smooth_clk | input | 1 | Jitter attenuator smoothing clock (asynchronous) |
| short_sense | input | 1 | Level from the analog driver short comparator |
| force_float | input | 1 | Test input: forces all output enables low |
| out_loss | output | 1 | Transmit clock loss flag |
| flag_oe | output | 1 | Output enable for the loss flag pin |
| drv_oe_p | output | 1 | Output enable, positive line driver |
| drv_oe_n | output | 1 | Output enable, negative line driver |

## Verification
Two things can fall in the same oscillator cycle: the strobe that closes a window and a synchronized edge of the watched clock. Such an edge has to count toward the window being closed and must not be lost. The bench provokes this by sweeping the watched clock's period from 2 to 14 oscillator cycles in both attenuator modes. Periods of 11 to 14 walk the edge phase through every cycle of the window, the strobe cycle included. The number of high cycles of the loss flag is then compared with the count worked out from window arithmetic, so a dropped or double-counted coincident edge changes the total. The short timer is judged the same way: the length of each off interval is measured in oscillator cycles and compared with 35 times the clock period.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

    // Which clock the presence monitor watches
    typedef enum logic {
        SRC_RAW_TX = 1'b0,
        SRC_SMOOTH = 1'b1
    } clk_src_e;

endpackage

// File: rtl/txmon_edge_sync.sv
module txmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[TOP] & ~st_q.prev;

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/txmon_window.sv
module txmon_window #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic loss_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
        logic          loss;
    } st_t;

    st_t  st_d, st_q;
    logic strobe;

    assign strobe = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.cnt  = '0;
            st_d.loss = !(st_q.seen || edge_i);
            st_d.seen = 1'b0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.seen = st_q.seen || edge_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loss_o = st_q.loss;

    // R1
    loss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.loss));

    // R1
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R2
    seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !st_q.seen);

endmodule

// File: rtl/txmon_guard.sv
module txmon_guard #(
    parameter int GUARD = 35,
    parameter int SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_edge_i,
    input  logic short_i,
    output logic prot_o
);
    localparam int CW = $clog2(GUARD);
    localparam logic [CW-1:0] LAST = CW'(GUARD - 1);

    typedef struct packed {
        logic [SYNC-1:0] sh;
        logic            prot;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t  st_d, st_q;
    logic short_s;

    assign short_s = st_q.sh[SYNC-1];

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SYNC-2:0], short_i};
        if (!st_q.prot) begin
            if (bit_edge_i && short_s) begin
                st_d.prot = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (bit_edge_i) begin
            if (st_q.cnt == LAST) begin
                st_d.prot = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot_o = st_q.prot;

    // R6
    enter_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.prot) |-> $past(bit_edge_i));

    // R6
    leave_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.prot) |-> $past(bit_edge_i));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prot |-> (st_q.cnt < CW'(GUARD)));

endmodule

// File: rtl/txmon_top.sv
module txmon_top #(
    parameter int STROBE_DIV  = 10,
    parameter int GUARD_BITS  = 35,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_ATTEN   = 1'b1
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic atten_in_tx,
    input  logic tx_clk,
    input  logic smooth_clk,
    input  logic short_sense,
    input  logic force_float,
    output logic out_loss,
    output logic flag_oe,
    output logic drv_oe_p,
    output logic drv_oe_n
);
    import txmon_pkg::*;

    logic sel_rise;
    logic loss;
    logic prot;
    logic drv_en;

    generate
        if (HAS_ATTEN) begin : g_two_src
            logic     raw_rise;
            logic     smo_rise;
            clk_src_e src;

            txmon_edge_sync #(.STAGES(SYNC_STAGES)) u_raw_sync (
                .clk(clk_osc), .rst_n(rst_n), .async_in(tx_clk), .rise_o(raw_rise));
            txmon_edge_sync #(.STAGES(SYNC_STAGES)) u_smo_sync (
                .clk(clk_osc), .rst_n(rst_n), .async_in(smooth_clk), .rise_o(smo_rise));

            assign src      = clk_src_e'(atten_in_tx);
            assign sel_rise = (src == SRC_SMOOTH) ? smo_rise : raw_rise;
        end else begin : g_one_src
            txmon_edge_sync #(.STAGES(SYNC_STAGES)) u_raw_sync (
                .clk(clk_osc), .rst_n(rst_n), .async_in(tx_clk), .rise_o(sel_rise));
        end
    endgenerate

    txmon_window #(.DIV(STROBE_DIV)) u_window (
        .clk(clk_osc), .rst_n(rst_n), .edge_i(sel_rise), .loss_o(loss));

    txmon_guard #(.GUARD(GUARD_BITS), .SYNC(SYNC_STAGES)) u_guard (
        .clk(clk_osc), .rst_n(rst_n), .bit_edge_i(sel_rise),
        .short_i(short_sense), .prot_o(prot));

    assign drv_en   = ~force_float & ~loss & ~prot;
    assign out_loss = loss;
    assign flag_oe  = ~force_float;
    assign drv_oe_p = drv_en;
    assign drv_oe_n = drv_en;

endmodule

// File: tb/txmon_top_bench.sv
module txmon_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic atten_in_tx = 1'b0;
    logic tx_clk = 1'b0;
    logic smooth_clk = 1'b0;
    logic short_sense = 1'b0;
    logic force_float = 1'b0;
    logic out_loss, flag_oe, drv_oe_p, drv_oe_n;

    int tx_per = 0;
    int sm_per = 0;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    txmon_top u_txmon_top (
        .clk_osc(clk), .rst_n(rst_n), .atten_in_tx(atten_in_tx),
        .tx_clk(tx_clk), .smooth_clk(smooth_clk), .short_sense(short_sense),
        .force_float(force_float), .out_loss(out_loss), .flag_oe(flag_oe),
        .drv_oe_p(drv_oe_p), .drv_oe_n(drv_oe_n));

    // periodic clocks measured in oscillator cycles; 0 means stopped
    initial forever begin
        int p;
        p = tx_per;
        if (p == 0) begin tx_clk = 1'b0; @(negedge clk); end
        else begin
            tx_clk = 1'b1; repeat (p / 2) @(negedge clk);
            tx_clk = 1'b0; repeat (p - p / 2) @(negedge clk);
        end
    end

    initial forever begin
        int p;
        p = sm_per;
        if (p == 0) begin smooth_clk = 1'b0; @(negedge clk); end
        else begin
            smooth_clk = 1'b1; repeat (p / 2) @(negedge clk);
            smooth_clk = 1'b0; repeat (p - p / 2) @(negedge clk);
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: got=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    function automatic void set_clk(input bit mode, input int per);
        atten_in_tx = mode;
        if (mode) begin sm_per = per; tx_per = 0; end
        else      begin tx_per = per; sm_per = 0; end
    endfunction

    // count oscillator cycles with out_loss high over a span
    task automatic count_loss(input int span, output int highs);
        highs = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (out_loss) highs++;
        end
    endtask

    // wait for drv_oe_p to reach a level; returns cycles waited
    task automatic wait_oe(input bit lvl, input int limit, output int n);
        n = 0;
        while (drv_oe_p != lvl && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int h, n, off_len, on_len;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 out_loss", out_loss, 0);
        chk("R9 drv_oe_p", drv_oe_p, 1);
        chk("R9 drv_oe_n", drv_oe_n, 1);
        chk("R9 flag_oe", flag_oe, 1);

        // R3/R4: no clock at all
        repeat (30) @(negedge clk);
        chk("R3 stopped clock flag", out_loss, 1);
        chk("R4 drv_oe_p off on loss", drv_oe_p, 0);
        chk("R4 drv_oe_n off on loss", drv_oe_n, 0);

        for (int mode = 0; mode < 2; mode++) begin
            // R2: periods up to one window never raise the flag
            for (int per = 2; per <= 10; per++) begin
                set_clk(mode[0], per);
                repeat (40) @(negedge clk);
                count_loss(60, h);
                chk($sformatf("R2 mode%0d per%0d high cycles", mode, per), h, 0);
                chk($sformatf("R2 mode%0d per%0d drv_oe", mode, per), drv_oe_p, 1);
            end
            // R1/R3: longer periods leave whole empty windows
            for (int per = 11; per <= 14; per++) begin
                set_clk(mode[0], per);
                repeat (60) @(negedge clk);
                count_loss(10 * per, h);
                chk($sformatf("R1 R3 mode%0d per%0d high cycles", mode, per), h, 10 * (per - 10));
            end
        end

        // R5: the unselected clock is ignored
        atten_in_tx = 1'b1; sm_per = 0; tx_per = 4;
        repeat (40) @(negedge clk);
        count_loss(30, h);
        chk("R5 smooth watched, raw running", h, 30);
        atten_in_tx = 1'b0; sm_per = 4; tx_per = 0;
        repeat (40) @(negedge clk);
        count_loss(30, h);
        chk("R5 raw watched, smooth running", h, 30);

        // R6/R7: short protection in both modes
        for (int mode = 0; mode < 2; mode++) begin
            int per;
            per = mode ? 7 : 4;
            set_clk(mode[0], per);
            repeat (40) @(negedge clk);
            short_sense = 1'b1;
            wait_oe(1'b0, 60, n);
            chk($sformatf("R6 mode%0d protection entered", mode), drv_oe_p, 0);
            wait_oe(1'b1, 2000, off_len);
            chk($sformatf("R6 mode%0d off length", mode), off_len, 35 * per);
            chk($sformatf("R6 mode%0d drv_oe_n follows", mode), drv_oe_n, 1);
            wait_oe(1'b0, 100, on_len);
            chk($sformatf("R7 mode%0d retry on length", mode), on_len, per);
            wait_oe(1'b1, 2000, off_len);
            chk($sformatf("R7 mode%0d second off length", mode), off_len, 35 * per);
            short_sense = 1'b0;
            wait_oe(1'b0, 100, n);
            wait_oe(1'b1, 2000, n);
            n = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!drv_oe_p) n++;
            end
            chk($sformatf("R6 mode%0d stays enabled after short clears", mode), n, 0);
        end

        // R8: forced float overrides everything
        set_clk(1'b0, 4);
        repeat (40) @(negedge clk);
        force_float = 1'b1;
        @(negedge clk);
        chk("R8 drv_oe_p forced", drv_oe_p, 0);
        chk("R8 drv_oe_n forced", drv_oe_n, 0);
        chk("R8 flag_oe forced", flag_oe, 0);
        tx_per = 0;
        repeat (40) @(negedge clk);
        chk("R8 flag_oe forced during loss", flag_oe, 0);
        chk("R3 flag under force", out_loss, 1);
        tx_per = 4;
        repeat (40) @(negedge clk);
        force_float = 1'b0;
        @(negedge clk);
        chk("R8 release drv_oe_p", drv_oe_p, 1);
        chk("R8 release flag_oe", flag_oe, 1);

        finish_run();
    end
endmodule